// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive and brings it up from power-on. Once reset is released it waits out a fixed start-up pause. It then asks the access controller for the memory bus and runs a group of dummy refresh cycles. Only after those cycles have finished does it raise `initDone`. While `initDone` is low, the access controller must hold off every host access.

After start-up, an interval timer adds one owed refresh per interval. The block holds `refReq` high while any refresh is owed. Each time the controller answers with `refGnt`, the block drives the strobes itself and runs CAS-before-RAS refresh cycles back to back. It lowers CAS ahead of RAS, holds RAS low for a fixed number of clocks and keeps a precharge gap between cycles. The DRAM chooses the row internally, so the block drives no address.

If the grant is held back, owed refreshes pile up to a small cap, and the whole backlog runs as one burst when the grant arrives. An idle watchdog measures how long RAS has stayed high, counting both the controller's RAS and the block's own. If that time reaches the retention limit, the block drops `initDone` and runs the dummy-cycle group again, without repeating the pause.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `rasN` and `casN` are high and `refReq` and `initDone` are low.
- R2: `refReq` stays low for the first PAUSE_CYC clocks after reset release and goes high within two clocks after that.
- R3: Exactly INIT_CYCLES refresh cycles are issued before `initDone` rises. It rises on the clock that ends the RAS-low phase of the last of them.
- R4: In every refresh cycle, `casN` falls while `rasN` is high and stays low for CAS_LEAD_CYC clocks before `rasN` falls. `rasN` is never low while `casN` is high.
- R5: `rasN` stays low for exactly RAS_LOW_CYC clocks per cycle and stays high for at least PRE_CYC clocks before the next fall.
- R6: While `initDone` is high, one refresh is owed every REF_INTERVAL clocks. With the grant always given, each owed refresh runs before the next one is owed.
- R7: Owed refreshes are counted up to MAX_PEND and no further. A late grant runs the whole backlog as one back-to-back burst.
- R8: A refresh cycle starts, meaning `casN` falls, only on a clock where `refGnt` was high.
- R9: If neither RAS source is low for IDLE_LIMIT consecutive clocks, `initDone` falls. INIT_CYCLES refresh cycles are then issued again with no new pause, and `initDone` rises again after them.
- R10: A low level on `hostRasN` restarts the idle watchdog, so regular host activity keeps `initDone` high while no refresh is granted.
- R11: `refReq` falls once the last owed cycle has finished its precharge. Whenever `refReq` is low, `rasN` and `casN` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostRasN | input | 1 | RAS level driven by the access controller, used by the idle watchdog |
| refGnt | input | 1 | Bus grant from the access controller |
| refReq | output | 1 | Bus request: refreshes are owed or a cycle is in progress |
| rasN | output | 1 | RAS strobe while granted, active low |
| casN | output | 1 | CAS strobe while granted, active low |
| initDone | output | 1 | High once pause and initialization cycles are complete |

## Verification
The in-line properties check on every clock the rules that need no history beyond a few cycles:
- CAS falls before RAS, and RAS is never low without CAS.
- The RAS-low width and the precharge gap are correct.
- No cycle starts without a grant.
- Both strobes are released whenever no request is pending.
- The owed count respects its cap during normal running.

The counting behaviours only show across a bench scenario:
- the length of the start-up pause;
- exactly eight dummy cycles before `initDone`;
- the refresh rate over a long window;
- the size of a backlog burst after a late grant;
- the watchdog firing, and host RAS activity holding it off.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CASLEAD,
    ST_RASLOW,
    ST_PRECHG
  } seqState_t;

  typedef enum logic [1:0] {
    PH_CASLEAD,
    PH_RASLOW,
    PH_PRECHG
  } phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      loadInit;   // load the init-cycle count into the owed counter
    logic      retire;     // one refresh cycle completed its RAS-low phase
    logic      loadPhase;  // restart the phase timer
    phaseSel_t phaseSel;   // which phase length to load
    logic      timerRun;   // interval timer enabled
    logic      idleRun;    // idle watchdog enabled
  } seqCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic pauseDone;
    logic pendAny;
    logic pendLast;
    logic phaseEnd;
    logic idleExpire;
  } seqStat_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 780,
  parameter int IDLE_LIMIT   = 820000,
  parameter int MAX_PEND     = 4,
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 3,
  parameter int PRE_CYC      = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  seqCtl_t  ctl,
  input  logic     ownRasLow,
  input  logic     hostRasN,
  output seqStat_t stat
);

  localparam int PAUSE_W  = $clog2(PAUSE_CYC + 1);
  localparam int IVL_W    = $clog2(REF_INTERVAL + 1);
  localparam int IDLE_W   = $clog2(IDLE_LIMIT + 1);
  localparam int PEND_TOP = (INIT_CYCLES > MAX_PEND) ? INIT_CYCLES : MAX_PEND;
  localparam int PEND_W   = $clog2(PEND_TOP + 1);
  localparam int PH_TOP0  = (CAS_LEAD_CYC > RAS_LOW_CYC) ? CAS_LEAD_CYC : RAS_LOW_CYC;
  localparam int PH_TOP   = (PH_TOP0 > PRE_CYC) ? PH_TOP0 : PRE_CYC;
  localparam int PH_W     = $clog2(PH_TOP + 1);

  // power-up pause timer, runs once after reset
  logic [PAUSE_W-1:0] pauseCnt;
  logic pauseEnd;
  assign pauseEnd = (pauseCnt == PAUSE_W'(PAUSE_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pauseCnt <= '0;
    else if (!pauseEnd) pauseCnt <= pauseCnt + 1'b1;
  end

  // refresh interval timer
  logic [IVL_W-1:0] ivlCnt;
  logic tick;
  assign tick = ctl.timerRun && (ivlCnt == IVL_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ivlCnt <= '0;
    else if (!ctl.timerRun) ivlCnt <= '0;
    else if (tick)          ivlCnt <= '0;
    else                    ivlCnt <= ivlCnt + 1'b1;
  end

  // owed-refresh counter
  logic [PEND_W-1:0] pendCnt;
  logic pendSat;
  assign pendSat = (pendCnt >= PEND_W'(MAX_PEND));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    pendCnt <= '0;
    else if (ctl.loadInit)        pendCnt <= PEND_W'(INIT_CYCLES);
    else if (tick && ctl.retire)  pendCnt <= pendCnt;
    else if (tick && !pendSat)    pendCnt <= pendCnt + 1'b1;
    else if (ctl.retire)          pendCnt <= pendCnt - 1'b1;
  end

  // idle watchdog: clocks since either RAS source was last low
  logic [IDLE_W-1:0] idleCnt;
  logic rasSeen, expire;
  assign rasSeen = ownRasLow || !hostRasN;
  assign expire  = ctl.idleRun && !rasSeen && (idleCnt == IDLE_W'(IDLE_LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 idleCnt <= '0;
    else if (!ctl.idleRun || rasSeen || expire) idleCnt <= '0;
    else                                       idleCnt <= idleCnt + 1'b1;
  end

  // phase timer for the strobe sequence
  logic [PH_W-1:0] phCnt, phLoad;

  always_comb begin
    case (ctl.phaseSel)
      PH_CASLEAD: phLoad = PH_W'(CAS_LEAD_CYC - 1);
      PH_RASLOW:  phLoad = PH_W'(RAS_LOW_CYC - 1);
      default:    phLoad = PH_W'(PRE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phCnt <= '0;
    else if (ctl.loadPhase) phCnt <= phLoad;
    else if (phCnt != '0)   phCnt <= phCnt - 1'b1;
  end

  assign stat.pauseDone  = pauseEnd;
  assign stat.pendAny    = (pendCnt != '0);
  assign stat.pendLast   = (pendCnt == PEND_W'(1));
  assign stat.phaseEnd   = (phCnt == '0);
  assign stat.idleExpire = expire;

  // R7: in normal running the backlog never passes its cap
  a_r7_pend_cap: assert property (@(posedge clk) disable iff (!rstN)
    ctl.timerRun |-> (pendCnt <= PEND_W'(MAX_PEND)));

  // R6: no refresh is owed by the timer before initialization is complete
  a_r6_timer_gated: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.timerRun |=> (ivlCnt == '0));

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import dram_rfsh_pkg::*;
#(
  parameter int RAS_LOW_CYC = 3,
  parameter int PRE_CYC     = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     refGnt,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     refReq,
  output logic     rasN,
  output logic     casN,
  output logic     initDone
);

  seqState_t state, stateNext;
  logic      doneSet;

  always_comb begin
    stateNext     = state;
    ctl.loadInit  = 1'b0;
    ctl.retire    = 1'b0;
    ctl.loadPhase = 1'b0;
    ctl.phaseSel  = PH_CASLEAD;
    ctl.timerRun  = initDone;
    ctl.idleRun   = (state != ST_PAUSE);
    doneSet       = 1'b0;
    case (state)
      ST_PAUSE: if (stat.pauseDone) begin
        ctl.loadInit = 1'b1;
        stateNext    = ST_IDLE;
      end
      ST_IDLE: if (stat.pendAny && refGnt) begin
        ctl.loadPhase = 1'b1;
        stateNext     = ST_CASLEAD;
      end
      ST_CASLEAD: if (stat.phaseEnd) begin
        ctl.loadPhase = 1'b1;
        ctl.phaseSel  = PH_RASLOW;
        stateNext     = ST_RASLOW;
      end
      ST_RASLOW: if (stat.phaseEnd) begin
        ctl.retire    = 1'b1;
        ctl.loadPhase = 1'b1;
        ctl.phaseSel  = PH_PRECHG;
        doneSet       = stat.pendLast && !initDone;
        stateNext     = ST_PRECHG;
      end
      default: if (stat.phaseEnd) begin
        if (stat.pendAny && refGnt) begin
          ctl.loadPhase = 1'b1;
          stateNext     = ST_CASLEAD;
        end else begin
          stateNext = ST_IDLE;
        end
      end
    endcase
    if (stat.idleExpire) ctl.loadInit = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PAUSE;
      initDone <= 1'b0;
    end else begin
      state <= stateNext;
      if (stat.idleExpire) initDone <= 1'b0;
      else if (doneSet)    initDone <= 1'b1;
    end
  end

  assign casN   = !(state == ST_CASLEAD || state == ST_RASLOW);
  assign rasN   = (state != ST_RASLOW);
  assign refReq = stat.pendAny || (state == ST_CASLEAD) || (state == ST_RASLOW) ||
                  (state == ST_PRECHG);

  // checker counters for strobe widths
  logic [7:0] lowLen, highLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLen  <= '0;
      highLen <= '0;
    end else if (!rasN) begin
      lowLen  <= lowLen + 1'b1;
      highLen <= '0;
    end else begin
      lowLen  <= '0;
      if (highLen < 8'(PRE_CYC)) highLen <= highLen + 1'b1;
    end
  end

  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSE) |-> !refReq);

  a_r4_cas_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> rasN);

  a_r4_ras_needs_cas: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN);

  a_r5_ras_width: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && lowLen != '0) |-> (lowLen == 8'(RAS_LOW_CYC)));

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (highLen >= 8'(PRE_CYC)));

  a_r8_grant_start: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(refGnt));

  a_r11_release: assert property (@(posedge clk) disable iff (!rstN)
    !refReq |-> (rasN && casN));

  a_r3_done_after_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> ($past(state) == ST_RASLOW));

  a_r9_drop_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(initDone) |-> rasN);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 780,
  parameter int IDLE_LIMIT   = 820000,
  parameter int MAX_PEND     = 4,
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 3,
  parameter int PRE_CYC      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostRasN,
  input  logic refGnt,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic initDone
);

  seqCtl_t  ctl;
  seqStat_t stat;

  rfsh_ctrl #(
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRE_CYC    (PRE_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .refGnt  (refGnt),
    .stat    (stat),
    .ctl     (ctl),
    .refReq  (refReq),
    .rasN    (rasN),
    .casN    (casN),
    .initDone(initDone)
  );

  rfsh_datapath #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INIT_CYCLES (INIT_CYCLES),
    .REF_INTERVAL(REF_INTERVAL),
    .IDLE_LIMIT  (IDLE_LIMIT),
    .MAX_PEND    (MAX_PEND),
    .CAS_LEAD_CYC(CAS_LEAD_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .PRE_CYC     (PRE_CYC)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .ownRasLow(!rasN),
    .hostRasN (hostRasN),
    .stat     (stat)
  );

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

  localparam int PAUSE    = 40;
  localparam int INITN    = 8;
  localparam int IVL      = 30;
  localparam int IDLE     = 300;
  localparam int MAXP     = 3;
  localparam int CASLEAD  = 1;
  localparam int RASLOW   = 3;
  localparam int PRE      = 2;

  typedef struct packed {
    int delay;
    int burst;
  } vec_t;

  // grant delay after request rise, expected refreshes in the burst (R7)
  localparam vec_t VEC [4] = '{
    '{delay: 5,  burst: 1},
    '{delay: 35, burst: 2},
    '{delay: 65, burst: 3},
    '{delay: 95, burst: 3}   // backlog would be 4, capped at MAXP
  };

  logic clk = 1'b0, rstN = 1'b0, hostRasN = 1'b1, refGnt = 1'b0;
  logic refReq, rasN, casN, initDone;
  bit autoGnt = 1'b0, manGnt = 1'b0, finished = 1'b0;
  int checks = 0, errors = 0;
  int falls = 0, lowRun = 0, highRun = 100, casRun = 0;
  logic prevRas = 1'b1;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INITN), .REF_INTERVAL(IVL), .IDLE_LIMIT(IDLE),
    .MAX_PEND(MAXP), .CAS_LEAD_CYC(CASLEAD), .RAS_LOW_CYC(RASLOW), .PRE_CYC(PRE)
  ) i_dram_refresh_seq (
    .clk(clk), .rstN(rstN), .hostRasN(hostRasN), .refGnt(refGnt),
    .refReq(refReq), .rasN(rasN), .casN(casN), .initDone(initDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) refGnt <= autoGnt ? refReq : manGnt;

  // strobe monitor: R4 and R5 on every refresh cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !rasN) begin
        falls++;
        check(casN == 1'b0, "R4 cas low at ras fall", casN, 0);
        check(casRun == CASLEAD, "R4 cas lead", casRun, CASLEAD);
        check(highRun >= PRE, "R5 precharge", highRun, PRE);
      end
      if (!prevRas && rasN) check(lowRun == RASLOW, "R5 ras low width", lowRun, RASLOW);
      if (!rasN) begin lowRun++; highRun = 0; end
      else begin highRun++; lowRun = 0; end
      if (!casN) casRun++; else casRun = 0;
      prevRas = rasN;
    end
  end

  task automatic waitReq(input logic lvl);
    for (int i = 0; i < 400; i++) begin
      if (refReq == lvl) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int start;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rasN == 1'b1 && casN == 1'b1, "R1 strobes high", {rasN, casN}, 3);
    check(refReq == 1'b0, "R1 no request", refReq, 0);
    check(initDone == 1'b0, "R1 init low", initDone, 0);
    rstN = 1'b1;

    // R2 pause
    repeat (PAUSE - 2) @(negedge clk);
    check(refReq == 1'b0, "R2 quiet during pause", refReq, 0);
    repeat (4) @(negedge clk);
    check(refReq == 1'b1, "R2 request after pause", refReq, 1);
    check(rasN == 1'b1, "R8 no cycle without grant", rasN, 1);

    // R3 initialization cycles
    start = falls;
    autoGnt = 1'b1;
    for (int i = 0; i < 300 && !initDone; i++) @(negedge clk);
    check(initDone == 1'b1, "R3 init done", initDone, 1);
    check(falls - start == INITN, "R3 init cycle count", falls - start, INITN);

    // R6 refresh rate with grant always given
    waitReq(1'b0);
    waitReq(1'b1);
    start = falls;
    repeat (290) @(negedge clk);
    check(falls - start == 10, "R6 refreshes per window", falls - start, 10);

    // R7 / R8 / R11 table of late grants
    autoGnt = 1'b0;
    manGnt  = 1'b0;
    waitReq(1'b0);
    foreach (VEC[k]) begin
      waitReq(1'b1);
      start = falls;
      repeat (VEC[k].delay) @(negedge clk);
      check(falls == start, "R8 idle until grant", falls - start, 0);
      manGnt = 1'b1;
      waitReq(1'b0);
      manGnt = 1'b0;
      check(falls - start == VEC[k].burst, "R7 burst size", falls - start, VEC[k].burst);
      check(rasN && casN, "R11 strobes released", {rasN, casN}, 3);
    end

    // R10 host RAS activity keeps the watchdog quiet
    for (int i = 0; i < 6; i++) begin
      repeat (80) @(negedge clk);
      hostRasN = 1'b0;
      @(negedge clk);
      hostRasN = 1'b1;
    end
    check(initDone == 1'b1, "R10 host activity holds init", initDone, 1);
    autoGnt = 1'b1;
    repeat (60) @(negedge clk);

    // R9 watchdog re-initialization
    autoGnt = 1'b0;
    repeat (IDLE + 40) @(negedge clk);
    check(initDone == 1'b0, "R9 init dropped after idle", initDone, 0);
    check(refReq == 1'b1, "R9 request for re-init", refReq, 1);
    start = falls;
    autoGnt = 1'b1;
    for (int i = 0; i < INITN * 6 + 20 && !initDone; i++) @(negedge clk);
    check(initDone == 1'b1, "R9 init restored without pause", initDone, 1);
    check(falls - start == INITN, "R9 re-init cycle count", falls - start, INITN);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule